// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out the atomic memory operations of a 64-bit virtual-machine instruction set against one memory port that uses a request/acknowledge handshake. The caller presents the access width, the 32-bit operation selector taken from the instruction immediate, the base register value, the signed 16-bit displacement, the source register value and the current value of register zero. The unit reads the target word and computes the updated value. It then writes that value back, except when a compare-and-swap misses. Finally it reports which register-file values the caller must update.

The unit supports add, OR, AND and XOR, each with or without returning the prior memory contents. It also supports unconditional swap and compare-and-swap. The memory port stays locked from the read request until the write completes, so no other agent can touch the location between the read and the write. Requests whose width or selector are not supported finish at once with an illegal flag and never reach memory.

Top module: `amo_engine`

## Requirements
- R1: A request is accepted only when `busy` is low. All request inputs are captured on the accepting edge, and later changes to them have no effect on the operation in flight.
- R2: The memory address is `req_base` plus `req_ofs` sign-extended to 64 bits. `mem_wide` is 1 for a 64-bit access and 0 for a 32-bit access. A 32-bit access returns and takes its data in bits 31:0 of the data buses.
- R3: The selector value is bits 7:0 of `req_imm`, and its code lives in bits 7:4. Code 0x0 stores old+src, 0x4 stores old|src, 0x5 stores old&src and 0xA stores old^src. In 32-bit mode only the low 32 bits take part, and the other half of the memory doubleword is left untouched.
- R4: Bit 0 of the selector is the fetch modifier. For add, OR, AND and XOR with fetch set, `src_we` pulses with `src_val` equal to the prior memory value, zero-extended in 32-bit mode. Without fetch, neither strobe fires.
- R5: Selector 0xE1 (swap) writes the source value and returns the prior memory value on `src_val` with `src_we`.
- R6: Selector 0xF1 (compare-and-swap) writes the source value only when the prior memory value equals `req_r0`. In 32-bit mode the comparison uses the low 32 bits only. On a miss, no write request is issued.
- R7: Compare-and-swap always pulses `r0_we` with `r0_val` equal to the prior memory value, zero-extended to 64 bits. It never pulses `src_we`.
- R8: A request is illegal in any of these cases: `req_size` is 2'b01 (halfword) or 2'b10 (byte), the selector code is not one of those above, bits 3:1 are not zero, bits 31:8 are not zero, or swap or compare-and-swap is given without fetch (0xE0, 0xF0). The legal sizes are 2'b00 for 32-bit and 2'b11 for 64-bit. An illegal request produces `done` with `illegal` high, no memory request and no strobe.
- R9: A legal operation issues exactly one read, then at most one write. `mem_lock` is high whenever `mem_req` is high and through the compute cycle between the two accesses, and low while idle.
- R10: `done` is a single-cycle pulse. The strobes and result values are valid in that cycle only.
- R11: `mem_req` is held high until `mem_ack` arrives, so that any number of memory wait cycles is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation |
| req_size | input | 2 | Access width code (00 32-bit, 01 half, 10 byte, 11 64-bit) |
| req_imm | input | 32 | Operation selector |
| req_base | input | 64 | Base register value |
| req_ofs | input | 16 | Signed displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register zero value (compare operand) |
| busy | output | 1 | Operation in flight |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 64-bit |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data |
| mem_ack | input | 1 | Access complete |
| mem_lock | output | 1 | Memory port held for the atomic sequence |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Request rejected (valid with done) |
| src_we | output | 1 | Write `src_val` to the source register |
| src_val | output | 64 | Value for the source register |
| r0_we | output | 1 | Write `r0_val` to register zero |
| r0_val | output | 64 | Value for register zero |

## Verification
Two things can coincide in one cycle: the memory acknowledge that ends an access, and a fresh request presented while the unit is still busy. The bench holds `req_valid` high for a whole operation with added memory wait cycles. Right after acceptance it changes the selector and source value to those of a different operation. The result, the final memory word and the counts of reads and writes must match the operation that was first accepted. A `done` pulse must then be followed by idle, with no second operation started.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_HALF  = 2'b01;
  localparam logic [1:0] SZ_BYTE  = 2'b10;
  localparam logic [1:0] SZ_DWORD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE,
    ST_DONE
  } amo_state_e;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_SWAP,
    OP_CAS
  } amo_op_e;

  typedef struct packed {
    amo_op_e op;
    logic    fetch;
    logic    wide;
    logic    bad;
  } amo_cmd_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [1:0]       size,
  input  logic [IMM_W-1:0] imm,
  output amo_cmd_t         cmd
);
  localparam int SEL_W = 8;

  logic hi_zero, mid_zero, size_ok, code_ok;
  amo_op_e op;

  assign hi_zero  = (imm[IMM_W-1:SEL_W] == '0);
  assign mid_zero = (imm[3:1] == 3'b000);
  assign size_ok  = (size == SZ_WORD) || (size == SZ_DWORD);

  always_comb begin
    op      = OP_ADD;
    code_ok = 1'b1;
    unique case (imm[7:4])
      4'h0:    op = OP_ADD;
      4'h4:    op = OP_OR;
      4'h5:    op = OP_AND;
      4'hA:    op = OP_XOR;
      4'hE: begin
        op      = OP_SWAP;
        code_ok = imm[0];
      end
      4'hF: begin
        op      = OP_CAS;
        code_ok = imm[0];
      end
      default: code_ok = 1'b0;
    endcase
  end

  assign cmd.op    = op;
  assign cmd.fetch = imm[0];
  assign cmd.wide  = (size == SZ_DWORD);
  assign cmd.bad   = !(size_ok && hi_zero && mid_zero && code_ok);

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] new_val,
  output logic              match
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] fit(input logic w, input logic [DATA_W-1:0] v);
    fit = w ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] combine(input amo_op_e o,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    unique case (o)
      OP_ADD:  combine = a + b;
      OP_OR:   combine = a | b;
      OP_AND:  combine = a & b;
      OP_XOR:  combine = a ^ b;
      default: combine = b;
    endcase
  endfunction

  assign match   = (fit(wide, old_val) == fit(wide, cmp_val));
  assign new_val = fit(wide, combine(op, old_val, opnd));

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bad,
  input  logic       mem_ack,
  input  logic       miss,
  output amo_state_e state,
  output logic       mem_req,
  output logic       mem_we,
  output logic       lock,
  output logic       done,
  output logic       rd_take
);
  amo_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = bad ? ST_DONE : ST_READ;
      ST_READ:  if (mem_ack) nxt = ST_CALC;
      ST_CALC:  nxt = miss ? ST_DONE : ST_WRITE;
      ST_WRITE: if (mem_ack) nxt = ST_DONE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign mem_req = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we  = (state == ST_WRITE);
  assign lock    = (state == ST_READ) || (state == ST_CALC) || (state == ST_WRITE);
  assign done    = (state == ST_DONE);
  assign rd_take = (state == ST_READ) && mem_ack;

endmodule

// File: rtl/amo_engine.sv
module amo_engine
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFS_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] req_r0,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              mem_lock,
  output logic              done,
  output logic              illegal,
  output logic              src_we,
  output logic [DATA_W-1:0] src_val,
  output logic              r0_we,
  output logic [DATA_W-1:0] r0_val
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ADDR_W - OFS_W;

  amo_cmd_t          dec_cmd, cmd_q;
  amo_state_e        state;
  logic              start, rd_take, match, skip_wr, op_wide;
  logic [ADDR_W-1:0] eff_addr, addr_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_val;

  amo_decode #(.IMM_W(IMM_W)) u_dec (
    .size (req_size),
    .imm  (req_imm),
    .cmd  (dec_cmd)
  );

  assign start    = req_valid && (state == ST_IDLE);
  assign eff_addr = req_base + {{EXT_W{req_ofs[OFS_W-1]}}, req_ofs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '{op: OP_ADD, fetch: 1'b0, wide: 1'b0, bad: 1'b0};
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      old_q  <= '0;
    end else begin
      if (start) begin
        cmd_q  <= dec_cmd;
        addr_q <= eff_addr;
        src_q  <= req_src;
        r0_q   <= req_r0;
      end
      if (rd_take)
        old_q <= cmd_q.wide ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
    end
  end

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (cmd_q.op),
    .wide    (cmd_q.wide),
    .old_val (old_q),
    .opnd    (src_q),
    .cmp_val (r0_q),
    .new_val (new_val),
    .match   (match)
  );

  assign skip_wr = (state == ST_CALC) && (cmd_q.op == OP_CAS) && !match;
  assign op_wide = cmd_q.wide;

  amo_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bad     (dec_cmd.bad),
    .mem_ack (mem_ack),
    .miss    (skip_wr),
    .state   (state),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .lock    (mem_lock),
    .done    (done),
    .rd_take (rd_take)
  );

  assign busy      = (state != ST_IDLE);
  assign mem_addr  = addr_q;
  assign mem_wdata = new_val;
  assign mem_wide  = cmd_q.wide;

  assign illegal = done && cmd_q.bad;
  assign src_we  = done && !cmd_q.bad && cmd_q.fetch && (cmd_q.op != OP_CAS);
  assign r0_we   = done && !cmd_q.bad && (cmd_q.op == OP_CAS);
  assign src_val = old_q;
  assign r0_val  = old_q;

endmodule

// File: rtl/amo_engine_chk.sv
module amo_engine_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_lock,
  input logic              done,
  input logic              illegal,
  input logic              src_we,
  input logic              r0_we,
  input logic [DATA_W-1:0] src_val,
  input logic [DATA_W-1:0] r0_val,
  input logic              skip_wr,
  input logic              op_wide
);
  localparam int HALF_W = DATA_W / 2;

  a_r9_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r9_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_lock);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_strobe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (src_we || r0_we) |-> done);

  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(src_we && r0_we));

  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!src_we && !r0_we && !mem_req));

  a_r6_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    skip_wr |=> (!mem_req && done));

  a_r3_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !op_wide) |->
      (src_val[DATA_W-1:HALF_W] == '0 && r0_val[DATA_W-1:HALF_W] == '0));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

endmodule

bind amo_engine amo_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_lock (mem_lock),
  .done     (done),
  .illegal  (illegal),
  .src_we   (src_we),
  .r0_we    (r0_we),
  .src_val  (src_val),
  .r0_val   (r0_val),
  .skip_wr  (skip_wr),
  .op_wide  (op_wide)
);

// File: tb/tb_amo_engine.sv
module tb_amo_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_imm = '0;
  logic [63:0] req_base = '0;
  logic [15:0] req_ofs = '0;
  logic [63:0] req_src = '0;
  logic [63:0] req_r0 = '0;
  logic        busy, mem_req, mem_we, mem_wide, mem_lock;
  logic [63:0] mem_addr, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        done, illegal, src_we, r0_we;
  logic [63:0] src_val, r0_val;

  always #2 clk = ~clk;

  amo_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_imm(req_imm), .req_base(req_base), .req_ofs(req_ofs), .req_src(req_src),
    .req_r0(req_r0), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_lock(mem_lock), .done(done),
    .illegal(illegal), .src_we(src_we), .src_val(src_val), .r0_we(r0_we),
    .r0_val(r0_val)
  );

  // memory model: 16 doublewords, word lanes chosen by address bit 2
  logic [63:0] mem [16];
  int          rd_cnt = 0, wr_cnt = 0, lock_bad = 0, wcnt = 0, lat = 0;
  logic [63:0] last_addr = '0;
  logic        last_wide = 1'b0;
  logic [3:0]  idx;
  assign idx = mem_addr[6:3];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt < lat) wcnt <= wcnt + 1;
      else begin
        wcnt      <= 0;
        mem_ack   <= 1'b1;
        last_addr <= mem_addr;
        last_wide <= mem_wide;
        if (!mem_lock) lock_bad <= lock_bad + 1;
        if (mem_we) begin
          wr_cnt <= wr_cnt + 1;
          if (mem_wide)         mem[idx]        <= mem_wdata;
          else if (mem_addr[2]) mem[idx][63:32] <= mem_wdata[31:0];
          else                  mem[idx][31:0]  <= mem_wdata[31:0];
        end else begin
          rd_cnt    <= rd_cnt + 1;
          mem_rdata <= mem_wide ? mem[idx] :
                       {32'h0, (mem_addr[2] ? mem[idx][63:32] : mem[idx][31:0])};
        end
      end
    end else mem_ack <= 1'b0;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic        cap_ill, cap_swe, cap_rwe, cap_done_after;
  logic [63:0] cap_src, cap_r0;
  bit          timed_out;

  task automatic run_op(input logic [1:0] sz, input logic [31:0] imm, input logic [63:0] base,
                        input logic [15:0] ofs, input logic [63:0] src, input logic [63:0] r0,
                        input bit hold);
    rd_cnt    <= 0;
    wr_cnt    <= 0;
    req_size  = sz;
    req_imm   = imm;
    req_base  = base;
    req_ofs   = ofs;
    req_src   = src;
    req_r0    = r0;
    req_valid = 1'b1;
    @(negedge clk);
    if (hold) begin
      req_imm  = 32'h0000_00F1;
      req_src  = 64'hBAD0_BAD0_BAD0_BAD0;
      req_r0   = 64'h0;
      req_size = 2'b01;
    end else req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    timed_out = !done;
    cap_ill   = illegal;
    cap_swe   = src_we;
    cap_rwe   = r0_we;
    cap_src   = src_val;
    cap_r0    = r0_val;
    req_valid = 1'b0;
    @(negedge clk);
    cap_done_after = done;
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic [31:0] imm;
    logic [63:0] mem0;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] exp_mem;
    logic        swe;
    logic [63:0] exp_src;
    logic        rwe;
    logic [63:0] exp_r0;
    logic        ill;
    logic        wr;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{2'b11, 32'h00, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0, 64'h0000_0002_0000_0000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b11, 32'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h0, 64'h1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b00, 32'h01, 64'hAAAA_AAAA_FFFF_FFFF, 64'h0000_0005_0000_0002, 64'h0, 64'hAAAA_AAAA_0000_0001, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b11, 32'h41, 64'h0000_0000_0000_00F0, 64'h0F00_0000_0000_000F, 64'h0, 64'h0F00_0000_0000_00FF, 1'b1, 64'hF0, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b11, 32'h50, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 64'h0F00_0F00_0F00_0F00, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b00, 32'hA1, 64'h1234_5678_0000_FFFF, 64'hFFFF_FFFF_FFFF_0000, 64'h0, 64'h1234_5678_FFFF_FFFF, 1'b1, 64'h0000_FFFF, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b00, 32'h40, 64'h5555_5555_0000_0F0F, 64'hFFFF_FFFF_F0F0_0000, 64'h0, 64'h5555_5555_F0F0_0F0F, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b11, 32'hE1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0, 64'h5555_6666_7777_8888, 1'b1, 64'h1111_2222_3333_4444, 1'b0, 64'h0, 1'b0, 1'b1},
    '{2'b11, 32'hF1, 64'hDEAD_BEEF_0000_0001, 64'h42, 64'hDEAD_BEEF_0000_0001, 64'h42, 1'b0, 64'h0, 1'b1, 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b1},
    '{2'b11, 32'hF1, 64'hDEAD_BEEF_0000_0001, 64'h42, 64'hDEAD_BEEF_0000_0002, 64'hDEAD_BEEF_0000_0001, 1'b0, 64'h0, 1'b1, 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0},
    '{2'b00, 32'hF1, 64'h7777_7777_CAFE_F00D, 64'h9999_9999_1234_5678, 64'hFFFF_FFFF_CAFE_F00D, 64'h7777_7777_1234_5678, 1'b0, 64'h0, 1'b1, 64'h0000_0000_CAFE_F00D, 1'b0, 1'b1},
    '{2'b00, 32'hF1, 64'h7777_7777_CAFE_F00D, 64'h9999_9999_1234_5678, 64'h0000_0000_CAFE_F00E, 64'h7777_7777_CAFE_F00D, 1'b0, 64'h0, 1'b1, 64'h0000_0000_CAFE_F00D, 1'b0, 1'b0},
    '{2'b01, 32'h00, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{2'b10, 32'h01, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{2'b11, 32'hE0, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{2'b11, 32'hF0, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{2'b11, 32'h30, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{2'b11, 32'h100, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{2'b00, 32'h02, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    string tag;
    for (int k = 0; k < 16; k++) mem[k] = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9, R10)
    chk("R10", "done after reset", {63'h0, done}, 64'h0);
    chk("R9", "lock after reset", {63'h0, mem_lock}, 64'h0);
    chk("R9", "req after reset", {63'h0, mem_req}, 64'h0);
    chk("R1", "busy after reset", {63'h0, busy}, 64'h0);

    // table walk at address 0x40 (doubleword 8, lane 0)
    for (int v = 0; v < NV; v++) begin
      if (VT[v].ill) tag = "R8";
      else if (VT[v].imm[7:4] == 4'hF) tag = "R6/R7";
      else if (VT[v].imm[7:4] == 4'hE) tag = "R5";
      else tag = "R3/R4";
      mem[8] <= VT[v].mem0;
      @(negedge clk);
      run_op(VT[v].sz, VT[v].imm, 64'h40, 16'h0, VT[v].src, VT[v].r0, 1'b0);
      chk(tag, $sformatf("v%0d timeout", v), {63'h0, timed_out}, 64'h0);
      chk(tag, $sformatf("v%0d illegal", v), {63'h0, cap_ill}, {63'h0, VT[v].ill});
      chk(tag, $sformatf("v%0d src_we", v), {63'h0, cap_swe}, {63'h0, VT[v].swe});
      chk(tag, $sformatf("v%0d r0_we", v), {63'h0, cap_rwe}, {63'h0, VT[v].rwe});
      if (VT[v].swe) chk(tag, $sformatf("v%0d src_val", v), cap_src, VT[v].exp_src);
      if (VT[v].rwe) chk(tag, $sformatf("v%0d r0_val", v), cap_r0, VT[v].exp_r0);
      chk(tag, $sformatf("v%0d memory", v), mem[8], VT[v].exp_mem);
      chk("R9", $sformatf("v%0d reads", v), 64'(rd_cnt), VT[v].ill ? 64'd0 : 64'd1);
      chk("R9", $sformatf("v%0d writes", v), 64'(wr_cnt), {63'h0, VT[v].wr});
      chk("R10", $sformatf("v%0d done pulse", v), {63'h0, cap_done_after}, 64'h0);
    end

    // R2: negative displacement, 64-bit access
    mem[3] <= 64'h0000_0000_0000_0077;
    @(negedge clk);
    run_op(2'b11, 32'h01, 64'h58, 16'hFFC0, 64'h1, 64'h0, 1'b0);
    chk("R2", "neg ofs addr", last_addr, 64'h18);
    chk("R2", "wide flag", {63'h0, last_wide}, 64'h1);
    chk("R2", "neg ofs data", mem[3], 64'h78);
    chk("R4", "neg ofs fetch", cap_src, 64'h77);

    // R2: positive displacement into the upper word lane, 32-bit swap
    mem[5] <= 64'hAAAA_BBBB_CCCC_DDDD;
    @(negedge clk);
    run_op(2'b00, 32'hE1, 64'h20, 16'h000C, 64'hFFFF_FFFF_0000_0001, 64'h0, 1'b0);
    chk("R2", "pos ofs addr", last_addr, 64'h2C);
    chk("R2", "narrow flag", {63'h0, last_wide}, 64'h0);
    chk("R5", "lane1 memory", mem[5], 64'h0000_0001_CCCC_DDDD);
    chk("R5", "lane1 old", cap_src, 64'h0000_0000_AAAA_BBBB);

    // R1/R11: wait cycles, request held and changed while busy
    lat = 3;
    mem[8] <= 64'h0000_0000_0000_0010;
    @(negedge clk);
    run_op(2'b11, 32'h01, 64'h40, 16'h0, 64'h5, 64'h0, 1'b1);
    chk("R11", "wait timeout", {63'h0, timed_out}, 64'h0);
    chk("R1", "held memory", mem[8], 64'h15);
    chk("R1", "held src_we", {63'h0, cap_swe}, 64'h1);
    chk("R1", "held r0_we", {63'h0, cap_rwe}, 64'h0);
    chk("R1", "held old", cap_src, 64'h10);
    chk("R1", "held reads", 64'(rd_cnt), 64'd1);
    chk("R1", "held writes", 64'(wr_cnt), 64'd1);
    chk("R10", "held done pulse", {63'h0, cap_done_after}, 64'h0);
    @(negedge clk);
    chk("R1", "idle after held", {63'h0, busy}, 64'h0);
    lat = 0;

    chk("R9", "lock during access", 64'(lock_bad), 64'd0);
    finish_run();
  end

endmodule